// File: doc/BRIEF.md
# Iterative XTEA Block Cipher Engine

This block encrypts or decrypts one 64-bit block under a 128-bit key with the XTEA Feistel cipher. The block is split into two 32-bit halves, v0 and v1. A single shared half-round datapath updates one half per clock. A full cycle is two half updates, so the default 32 cycles take 64 clocks.

A client drives the key, the block and the direction, then pulses `start` while `ready` is high. The engine captures all inputs on that edge and works on its own copy. When it finishes, it raises `ready` and `result_valid` together. The result stays on `result` until the next accepted start.

Top module: `xtea_core`

## Requirements
- R1: While reset is asserted and after it is released, `ready` is 1, `result_valid` is 0 and `result` is all zeros.
- R2: Layout: v0 is `block_in[63:32]` and v1 is `block_in[31:0]`. Key word 0 is `key[127:96]`, word 1 is `key[95:64]`, word 2 is `key[63:32]` and word 3 is `key[31:0]`. `result` uses the same half layout as `block_in`.
- R3: Encryption (`decrypt`=0) starts with sum = 0 and repeats the following 32 times, modulo 2^32. First, v0 += F(v1) ^ (sum + word[sum[1:0]]). Then sum += 0x9E3779B9. Then v1 += F(v0) ^ (sum + word[sum[12:11]]). Here F(x) = ((x<<4) ^ (x>>5)) + x.
- R4: Decryption (`decrypt`=1) starts with sum = 0x9E3779B9*32 mod 2^32 and repeats the following 32 times. First, v1 -= F(v0) ^ (sum + word[sum[12:11]]). Then sum -= 0x9E3779B9. Then v0 -= F(v1) ^ (sum + word[sum[1:0]]).
- R5: A start is accepted on a clock edge where `start` and `ready` are both 1. `ready` and `result_valid` are 0 after that edge. Both return to 1 exactly 64 clock edges after the accepting edge.
- R6: While `ready` is 0, `start` is ignored. Changes on `key`, `block_in` and `decrypt` during processing are also ignored. The result and the latency are those of the accepted operation.
- R7: `result_valid` is never 1 while `ready` is 0. While idle without a start, `result` and `result_valid` hold their values whatever the other inputs do.
- R8: Decrypting an encryption result under the same key returns the original block exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when ready |
| decrypt | input | 1 | 0 selects encryption, 1 decryption |
| key | input | 128 | Cipher key, word 0 in the top bits |
| block_in | input | 64 | Input block, v0 in the top half |
| ready | output | 1 | Engine idle and able to accept a start |
| result | output | 64 | Output block, v0 in the top half |
| result_valid | output | 1 | `result` holds a finished operation |

## Verification
Several handshake properties are checked on every clock:
- a start taken while idle drops `ready`;
- `ready` rises exactly 64 edges after the accepting edge, and `result_valid` rises with it;
- `result_valid` implies `ready`;
- an idle engine without a start keeps its result frozen;
- the engine stays busy until its count completes.

Only the bench scenarios can show the rest. These are the numeric cipher output for each direction and the half and key-word layout. They also include the round-trip identity, and the fact that a second start or changed inputs mid-operation leave the first operation's result intact. The bench sweeps a grid of keys and blocks, including all-zero and all-one patterns, against an arithmetic model.

// File: rtl/xtea_pkg.sv
package xtea_pkg;

   // Number of key words selected by the schedule
   localparam int unsigned KEY_WORDS = 4;

   // Which half update of a cycle is being performed
   typedef enum logic {
      HALF_A = 1'b0,
      HALF_B = 1'b1
   } half_e;

endpackage

// File: rtl/xtea_keysel.sv
module xtea_keysel
   import xtea_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic [KEY_WORDS*WORD_W-1:0] key,
   input  logic [1:0]                  idx,
   output logic [WORD_W-1:0]           word
);

   logic [WORD_W-1:0] words [KEY_WORDS];

   // Word 0 lives in the most significant slice
   for (genvar g = 0; g < KEY_WORDS; g++) begin : g_unpack
      assign words[g] = key[(KEY_WORDS-g)*WORD_W-1 -: WORD_W];
   end

   assign word = words[idx];

endmodule

// File: rtl/xtea_mix.sv
module xtea_mix #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SHL    = 4,
   parameter int unsigned SHR    = 5
) (
   input  logic [WORD_W-1:0] target,
   input  logic [WORD_W-1:0] other,
   input  logic [WORD_W-1:0] sum,
   input  logic [WORD_W-1:0] kword,
   input  logic              subtract,
   output logic [WORD_W-1:0] next
);

   logic [WORD_W-1:0] spread;
   logic [WORD_W-1:0] tweak;
   logic [WORD_W-1:0] f_val;

   always_comb begin
      spread = ((other << SHL) ^ (other >> SHR)) + other;
      tweak  = sum + kword;
      f_val  = spread ^ tweak;
      next   = subtract ? (target - f_val) : (target + f_val);
   end

endmodule

// File: rtl/xtea_sched.sv
module xtea_sched
   import xtea_pkg::*;
#(
   parameter int unsigned        WORD_W = 32,
   parameter int unsigned        CYCLES = 32,
   parameter logic [WORD_W-1:0]  DELTA  = 'h9E3779B9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              decrypt,
   output logic              load,
   output logic              step,
   output half_e             phase,
   output logic              dec_mode,
   output logic [WORD_W-1:0] sum,
   output logic              ready,
   output logic              done_valid
);

   localparam int unsigned          CNT_W   = $clog2(CYCLES + 1);
   localparam logic [2*WORD_W-1:0]  PROD    = (2*WORD_W)'(DELTA) * (2*WORD_W)'(CYCLES);
   localparam logic [WORD_W-1:0]    SUM_DEC = PROD[WORD_W-1:0];
   localparam logic [CNT_W-1:0]     LAST    = CNT_W'(CYCLES - 1);

   logic              busy_q;
   half_e             phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sum_q;
   logic              dec_q;
   logic              valid_q;
   logic              last_cycle;

   assign load       = start & ~busy_q;
   assign step       = busy_q;
   assign last_cycle = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= HALF_A;
         cnt_q   <= '0;
         sum_q   <= '0;
         dec_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (load) begin
         busy_q  <= 1'b1;
         phase_q <= HALF_A;
         cnt_q   <= '0;
         sum_q   <= decrypt ? SUM_DEC : '0;
         dec_q   <= decrypt;
         valid_q <= 1'b0;
      end else if (busy_q) begin
         if (phase_q == HALF_A) begin
            sum_q   <= dec_q ? (sum_q - DELTA) : (sum_q + DELTA);
            phase_q <= HALF_B;
         end else begin
            phase_q <= HALF_A;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (last_cycle) begin
               busy_q  <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign phase      = phase_q;
   assign dec_mode   = dec_q;
   assign sum        = sum_q;
   assign ready      = ~busy_q;
   assign done_valid = valid_q;

endmodule

// File: rtl/xtea_datapath.sv
module xtea_datapath
   import xtea_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned SHL     = 4,
   parameter int unsigned SHR     = 5,
   parameter int unsigned KSEL_HI = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic                        step,
   input  half_e                       phase,
   input  logic                        dec_mode,
   input  logic [WORD_W-1:0]           sum,
   input  logic [KEY_WORDS*WORD_W-1:0] key_in,
   input  logic [2*WORD_W-1:0]         block_in,
   output logic [2*WORD_W-1:0]         block_out
);

   logic [WORD_W-1:0]           v0_q, v1_q;
   logic [KEY_WORDS*WORD_W-1:0] key_q;
   logic                        upd_v0;
   logic [WORD_W-1:0]           target, other, kword, next;
   logic [1:0]                  kidx;

   // Encryption touches v0 on the first half, decryption on the second
   assign upd_v0 = (phase == HALF_A) ^ dec_mode;
   assign target = upd_v0 ? v0_q : v1_q;
   assign other  = upd_v0 ? v1_q : v0_q;
   assign kidx   = upd_v0 ? sum[1:0] : sum[KSEL_HI+1:KSEL_HI];

   xtea_keysel #(.WORD_W(WORD_W)) u_keysel (
      .key  (key_q),
      .idx  (kidx),
      .word (kword)
   );

   xtea_mix #(.WORD_W(WORD_W), .SHL(SHL), .SHR(SHR)) u_mix (
      .target   (target),
      .other    (other),
      .sum      (sum),
      .kword    (kword),
      .subtract (dec_mode),
      .next     (next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v0_q  <= '0;
         v1_q  <= '0;
         key_q <= '0;
      end else if (load) begin
         v0_q  <= block_in[2*WORD_W-1:WORD_W];
         v1_q  <= block_in[WORD_W-1:0];
         key_q <= key_in;
      end else if (step) begin
         if (upd_v0) v0_q <= next;
         else        v1_q <= next;
      end
   end

   assign block_out = {v0_q, v1_q};

endmodule

// File: rtl/xtea_core.sv
module xtea_core
   import xtea_pkg::*;
#(
   parameter int unsigned       WORD_W  = 32,
   parameter int unsigned       CYCLES  = 32,
   parameter logic [WORD_W-1:0] DELTA   = 'h9E3779B9,
   parameter int unsigned       SHL     = 4,
   parameter int unsigned       SHR     = 5,
   parameter int unsigned       KSEL_HI = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        decrypt,
   input  logic [KEY_WORDS*WORD_W-1:0] key,
   input  logic [2*WORD_W-1:0]         block_in,
   output logic                        ready,
   output logic [2*WORD_W-1:0]         result,
   output logic                        result_valid
);

   // Elaboration-time parameter checks
   if (CYCLES < 1) begin : g_bad_cycles
      $error("xtea_core: CYCLES must be at least 1");
   end
   if (KSEL_HI + 1 >= WORD_W) begin : g_bad_ksel
      $error("xtea_core: KSEL_HI+1 must index inside a word");
   end
   if (SHL >= WORD_W || SHR >= WORD_W) begin : g_bad_shift
      $error("xtea_core: shift amounts must be below WORD_W");
   end

   logic              load, step, dec_mode;
   half_e             phase;
   logic [WORD_W-1:0] sum;

   xtea_sched #(.WORD_W(WORD_W), .CYCLES(CYCLES), .DELTA(DELTA)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .decrypt    (decrypt),
      .load       (load),
      .step       (step),
      .phase      (phase),
      .dec_mode   (dec_mode),
      .sum        (sum),
      .ready      (ready),
      .done_valid (result_valid)
   );

   xtea_datapath #(.WORD_W(WORD_W), .SHL(SHL), .SHR(SHR), .KSEL_HI(KSEL_HI)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (step),
      .phase     (phase),
      .dec_mode  (dec_mode),
      .sum       (sum),
      .key_in    (key),
      .block_in  (block_in),
      .block_out (result)
   );

endmodule

// File: rtl/xtea_core_chk.sv
module xtea_core_chk #(
   parameter int unsigned BLOCK_W = 64,
   parameter int unsigned CYCLES  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               ready,
   input logic               result_valid,
   input logic [BLOCK_W-1:0] result
);

   localparam int unsigned CW = $clog2(2*CYCLES + 1) + 1;

   logic [CW-1:0] busy_cnt;

   // Counts edges spent busy since the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               busy_cnt <= '0;
      else if (ready && start)  busy_cnt <= '0;
      else if (!ready)          busy_cnt <= busy_cnt + CW'(1);
   end

   p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && start) |=> (!ready && !result_valid));

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (busy_cnt == CW'(2*CYCLES)));

   p_done_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> result_valid);

   p_valid_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> ready);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> (ready && $stable(result) && $stable(result_valid)));

   p_stay_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && busy_cnt < CW'(2*CYCLES - 1)) |=> !ready);

endmodule

bind xtea_core xtea_core_chk #(.BLOCK_W(2*WORD_W), .CYCLES(CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .ready        (ready),
   .result_valid (result_valid),
   .result       (result)
);

// File: tb/xtea_core_test.sv
`timescale 1ns/1ps
module xtea_core_test;

   localparam logic [31:0] DLT = 32'h9E3779B9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         decrypt = 1'b0;
   logic [127:0] key = '0;
   logic [63:0]  block_in = '0;
   logic         ready;
   logic [63:0]  result;
   logic         result_valid;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   xtea_core uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .decrypt      (decrypt),
      .key          (key),
      .block_in     (block_in),
      .ready        (ready),
      .result       (result),
      .result_valid (result_valid)
   );

   function automatic logic [31:0] f_of(input logic [31:0] x);
      return ((x << 4) ^ (x >> 5)) + x;
   endfunction

   function automatic logic [31:0] kw(input logic [127:0] k, input logic [1:0] i);
      return k[127 - 32*i -: 32];
   endfunction

   // Arithmetic model of R2, R3 and R4
   function automatic logic [63:0] model(input bit dec, input logic [127:0] k,
                                         input logic [63:0] b);
      logic [31:0] v0, v1, s;
      v0 = b[63:32];
      v1 = b[31:0];
      if (!dec) begin
         s = 32'h0;
         for (int r = 0; r < 32; r++) begin
            v0 = v0 + (f_of(v1) ^ (s + kw(k, s[1:0])));
            s  = s + DLT;
            v1 = v1 + (f_of(v0) ^ (s + kw(k, s[12:11])));
         end
      end else begin
         s = DLT * 32'd32;
         for (int r = 0; r < 32; r++) begin
            v1 = v1 - (f_of(v0) ^ (s + kw(k, s[12:11])));
            s  = s - DLT;
            v0 = v0 - (f_of(v1) ^ (s + kw(k, s[1:0])));
         end
      end
      return {v0, v1};
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One operation with the R5 timing checked along the way
   task automatic run_op(input bit dec, input logic [127:0] k, input logic [63:0] b,
                         output logic [63:0] res);
      @(negedge clk);
      start = 1'b1; decrypt = dec; key = k; block_in = b;
      @(negedge clk);
      start = 1'b0;
      check(!ready && !result_valid, "R5 busy after accept", {62'd0, ready, result_valid}, 64'd0);
      repeat (63) @(negedge clk);
      check(!ready, "R5 still busy at edge 63", {63'd0, ready}, 64'd0);
      @(negedge clk);
      check(ready && result_valid, "R5 done at edge 64", {62'd0, ready, result_valid}, 64'd3);
      res = result;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog expired: actual %h expected %h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0]  ct, pt, got, orig_b, saved;
      logic [127:0] orig_k, k;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(ready && !result_valid && result == 64'd0, "R1 during reset",
            {result[63:2], ready, result_valid}, 64'd2);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready && !result_valid && result == 64'd0, "R1 after release",
            {result[63:2], ready, result_valid}, 64'd2);

      // Sweep keys and blocks: R2, R3, R4, R8
      for (int ki = 0; ki < 6; ki++) begin
         for (int j = 0; j < 4; j++)
            k[127 - 32*j -: 32] = (ki == 5) ? 32'hFFFF_FFFF :
                                  DLT * 32'(ki * 4 + j) ^ (32'h1357_9BDF << ki);
         if (ki == 0) k = '0;
         for (int bi = 0; bi < 4; bi++) begin
            case (bi)
               0:       pt = 64'd0;
               1:       pt = '1;
               default: pt = {32'h0123_4567 * 32'(bi + ki), 32'hFEDC_BA98 ^ 32'(bi << ki)};
            endcase
            run_op(1'b0, k, pt, ct);
            check(ct == model(1'b0, k, pt), "R3 R2 encrypt", ct, model(1'b0, k, pt));
            run_op(1'b1, k, ct, got);
            check(got == pt, "R8 round trip", got, pt);
            run_op(1'b1, k, pt, got);
            check(got == model(1'b1, k, pt), "R4 R2 decrypt", got, model(1'b1, k, pt));
         end
      end

      // R6: start and input changes mid-operation are ignored
      orig_k = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
      orig_b = 64'hDEAD_BEEF_0BAD_F00D;
      @(negedge clk);
      start = 1'b1; decrypt = 1'b0; key = orig_k; block_in = orig_b;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; decrypt = 1'b1; key = ~orig_k; block_in = ~orig_b;
      @(negedge clk);
      start = 1'b0;
      check(!ready, "R6 second start ignored", {63'd0, ready}, 64'd0);
      key = 128'h5; block_in = 64'h7;
      repeat (42) @(negedge clk);
      check(!ready, "R6 latency unchanged", {63'd0, ready}, 64'd0);
      @(negedge clk);
      check(ready && result_valid, "R6 done on time", {62'd0, ready, result_valid}, 64'd3);
      check(result == model(1'b0, orig_k, orig_b), "R6 result of first op",
            result, model(1'b0, orig_k, orig_b));

      // R7: idle hold with changing inputs
      saved = result;
      decrypt = 1'b1; key = '1; block_in = 64'h1234;
      repeat (5) @(negedge clk);
      check(result == saved && result_valid && ready, "R7 idle hold", result, saved);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule